// File: doc/BRIEF.md
# PC-Relative Address and Immediate Unit

This unit serves the program-counter-relative instruction group of a 64-bit integer pipeline. Each issued operation brings the current program counter, a 21-bit immediate field and a destination register number. The unit decodes the sub-operation from a prefix at the top of the immediate field. The prefix is five bits long for the two upper-immediate forms, three bits for the doubleword load and two bits for the rest. From that it either produces a 64-bit register result directly or issues a load to data memory and extends the returned data.

Non-load forms write back one cycle after issue. Load forms raise a request that carries an address, a size and an extension control, and hold it until the memory accepts it. After that the unit waits for the returned data and writes the extended value back one cycle after the data arrives. While a load is outstanding the unit refuses new operations. An immediate field that matches no prefix raises a one-cycle illegal flag and writes nothing.

Top module: `pcrel_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `issue_rdy` is 1 and `wb_valid`, `ld_req_valid` and `illegal` are 0.
- R2: Prefix `imm[20:16]`=11110 (add-upper): `wb_data` = pc + (sign-extended `imm[15:0]` shifted left 16), with `wb_valid` high in the cycle after issue.
- R3: Prefix `imm[20:16]`=11111 (aligned-upper): the same sum as R2 with bits 15:0 forced to zero, written back in the cycle after issue.
- R4: Prefix `imm[20:19]`=00 (add-immediate): `wb_data` = pc + (sign-extended `imm[18:0]` shifted left 2), written back in the cycle after issue.
- R5: Prefix `imm[20:19]`=01 (signed word load): request address pc + (sign-extended `imm[18:0]` << 2), `ld_dword`=0, `ld_signed`=1; result is `ld_data[31:0]` sign-extended to 64 bits.
- R6: Prefix `imm[20:19]`=10 (unsigned word load): same address as R5, `ld_dword`=0, `ld_signed`=0; result is `ld_data[31:0]` zero-extended.
- R7: Prefix `imm[20:18]`=110 (doubleword load): request address (pc with bits 2:0 cleared) + (sign-extended `imm[17:0]` << 3), `ld_dword`=1; result is all 64 bits of `ld_data`.
- R8: A load request keeps `ld_req_valid`, `ld_addr`, `ld_dword` and `ld_signed` unchanged until a cycle in which `ld_req_ready` is high.
- R9: From issue of a load until its write-back, `issue_rdy` is 0 and issued operations are ignored; `wb_valid` rises in the cycle after `ld_data_valid` is seen, and `issue_rdy` returns to 1 at the same time.
- R10: Prefixes 11100 and 11101 in `imm[20:16]` are illegal: `illegal` pulses for one cycle after issue with no write-back and no load request.
- R11: `wb_reg` equals the `in_dst` value given with the operation that produced the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issued this cycle (taken only when `issue_rdy` is 1) |
| in_pc | input | 64 | Program counter of the operation |
| in_imm | input | 21 | Immediate field holding the sub-operation prefix |
| in_dst | input | 5 | Destination register number |
| issue_rdy | output | 1 | Unit idle and able to take an operation |
| ld_req_valid | output | 1 | Load request pending |
| ld_req_ready | input | 1 | Memory accepts the pending request |
| ld_addr | output | 64 | Load byte address |
| ld_dword | output | 1 | 1 = 64-bit load, 0 = 32-bit load |
| ld_signed | output | 1 | 1 = sign-extend a 32-bit load, 0 = zero-extend |
| ld_data_valid | input | 1 | Load data present this cycle |
| ld_data | input | 64 | Load data, word loads in bits 31:0 |
| wb_valid | output | 1 | Register write this cycle |
| wb_reg | output | 5 | Register number to write |
| wb_data | output | 64 | Value to write |
| illegal | output | 1 | Unrecognised prefix, one-cycle pulse |

## Verification
The bench builds the unit with its default widths: a 64-bit program counter, a 21-bit immediate and 5-bit register numbers. These widths make the carry out of bit 31 of the program counter reachable, as well as the sign bit of each immediate slice (bits 15, 17 and 18) and the sign bit of a returned 32-bit word. Memory-side stalls of zero to four cycles before acceptance and before data exercise the hold and busy behaviour of loads.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

  typedef enum logic [2:0] {
    PR_ADD_UP  = 3'd0,
    PR_ALN_UP  = 3'd1,
    PR_ADD_IMM = 3'd2,
    PR_LDW_S   = 3'd3,
    PR_LDW_U   = 3'd4,
    PR_LDD     = 3'd5,
    PR_BAD     = 3'd7
  } pr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } pr_state_e;

  // Prefix codes, longest prefix wins
  localparam logic [4:0] PFX5_ADD_UP  = 5'b11110;
  localparam logic [4:0] PFX5_ALN_UP  = 5'b11111;
  localparam logic [2:0] PFX3_LDD     = 3'b110;
  localparam logic [1:0] PFX2_ADD_IMM = 2'b00;
  localparam logic [1:0] PFX2_LDW_S   = 2'b01;
  localparam logic [1:0] PFX2_LDW_U   = 2'b10;

  function automatic logic pr_is_load(input pr_op_e op);
    return (op == PR_LDW_S) || (op == PR_LDW_U) || (op == PR_LDD);
  endfunction

endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode
  import pcrel_pkg::*;
#(
  parameter int IMM_W = 21
) (
  input  logic [IMM_W-1:0] imm,
  output pr_op_e           op
);
  localparam int TOP = IMM_W - 1;

  logic [4:0] p5;
  logic [2:0] p3;
  logic [1:0] p2;

  assign p5 = imm[TOP -: 5];
  assign p3 = imm[TOP -: 3];
  assign p2 = imm[TOP -: 2];

  always_comb begin
    if (p5 == PFX5_ADD_UP)      op = PR_ADD_UP;
    else if (p5 == PFX5_ALN_UP) op = PR_ALN_UP;
    else if (p3 == PFX3_LDD)    op = PR_LDD;
    else begin
      case (p2)
        PFX2_ADD_IMM: op = PR_ADD_IMM;
        PFX2_LDW_S:   op = PR_LDW_S;
        PFX2_LDW_U:   op = PR_LDW_U;
        default:      op = PR_BAD;
      endcase
    end
  end

  logic unused_low;
  assign unused_low = ^imm[TOP-5:0];

endmodule

// File: rtl/pcrel_agen.sv
module pcrel_agen
  import pcrel_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 21
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  input  pr_op_e           op,
  output logic [XLEN-1:0]  result,
  output logic [XLEN-1:0]  addr
);
  localparam int UP_W  = IMM_W - 5;  // upper-immediate slice, also its shift
  localparam int WD_W  = IMM_W - 2;  // word-scaled slice
  localparam int DW_W  = IMM_W - 3;  // doubleword-scaled slice
  localparam int WD_SH = 2;
  localparam int DW_SH = 3;

  logic [XLEN-1:0] se_up, se_wd, se_dw;
  logic [XLEN-1:0] up_sum, wd_sum, pc_dw, dw_sum;

  assign se_up = {{(XLEN-UP_W){imm[UP_W-1]}}, imm[UP_W-1:0]};
  assign se_wd = {{(XLEN-WD_W){imm[WD_W-1]}}, imm[WD_W-1:0]};
  assign se_dw = {{(XLEN-DW_W){imm[DW_W-1]}}, imm[DW_W-1:0]};

  assign up_sum = pc + (se_up << UP_W);
  assign wd_sum = pc + (se_wd << WD_SH);
  assign pc_dw  = {pc[XLEN-1:DW_SH], {DW_SH{1'b0}}};
  assign dw_sum = pc_dw + (se_dw << DW_SH);

  always_comb begin
    case (op)
      PR_ADD_UP: result = up_sum;
      PR_ALN_UP: result = {up_sum[XLEN-1:UP_W], {UP_W{1'b0}}};
      default:   result = wd_sum;
    endcase
  end

  assign addr = (op == PR_LDD) ? dw_sum : wd_sum;

  logic unused_pfx;
  assign unused_pfx = ^imm[IMM_W-1:WD_W];

endmodule

// File: rtl/pcrel_ldext.sv
module pcrel_ldext
  import pcrel_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  pr_op_e          op,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] ext
);
  always_comb begin
    case (op)
      PR_LDD:   ext = raw;
      PR_LDW_S: ext = {{(XLEN-WORD){raw[WORD-1]}}, raw[WORD-1:0]};
      default:  ext = {{(XLEN-WORD){1'b0}}, raw[WORD-1:0]};
    endcase
  end
endmodule

// File: rtl/pcrel_unit.sv
module pcrel_unit
  import pcrel_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 21,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  in_pc,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [REG_W-1:0] in_dst,
  output logic             issue_rdy,
  output logic             ld_req_valid,
  input  logic             ld_req_ready,
  output logic [XLEN-1:0]  ld_addr,
  output logic             ld_dword,
  output logic             ld_signed,
  input  logic             ld_data_valid,
  input  logic [XLEN-1:0]  ld_data,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_reg,
  output logic [XLEN-1:0]  wb_data,
  output logic             illegal
);
  pr_state_e       state_q;
  pr_op_e          dec_op, op_q;
  logic [XLEN-1:0] alu_res, agen_addr, ld_ext;
  logic [XLEN-1:0] addr_q, wb_data_q;
  logic [REG_W-1:0] dst_q, wb_reg_q;
  logic            wb_valid_q, illegal_q;

  pcrel_decode #(.IMM_W(IMM_W)) u_dec (
    .imm (in_imm),
    .op  (dec_op)
  );

  pcrel_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .pc     (in_pc),
    .imm    (in_imm),
    .op     (dec_op),
    .result (alu_res),
    .addr   (agen_addr)
  );

  pcrel_ldext #(.XLEN(XLEN)) u_ext (
    .op  (op_q),
    .raw (ld_data),
    .ext (ld_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_q       <= PR_ADD_IMM;
      addr_q     <= '0;
      dst_q      <= '0;
      wb_valid_q <= 1'b0;
      wb_reg_q   <= '0;
      wb_data_q  <= '0;
      illegal_q  <= 1'b0;
    end else begin
      wb_valid_q <= 1'b0;
      illegal_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            if (dec_op == PR_BAD) begin
              illegal_q <= 1'b1;
            end else if (pr_is_load(dec_op)) begin
              op_q    <= dec_op;
              addr_q  <= agen_addr;
              dst_q   <= in_dst;
              state_q <= ST_REQ;
            end else begin
              wb_valid_q <= 1'b1;
              wb_reg_q   <= in_dst;
              wb_data_q  <= alu_res;
            end
          end
        end
        ST_REQ: begin
          if (ld_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ld_data_valid) begin
            wb_valid_q <= 1'b1;
            wb_reg_q   <= dst_q;
            wb_data_q  <= ld_ext;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign issue_rdy    = (state_q == ST_IDLE);
  assign ld_req_valid = (state_q == ST_REQ);
  assign ld_addr      = addr_q;
  assign ld_dword     = (op_q == PR_LDD);
  assign ld_signed    = (op_q == PR_LDW_S);
  assign wb_valid     = wb_valid_q;
  assign wb_reg       = wb_reg_q;
  assign wb_data      = wb_data_q;
  assign illegal      = illegal_q;

endmodule

// File: rtl/pcrel_unit_chk.sv
module pcrel_unit_chk #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 21,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IMM_W-1:0] in_imm,
  input logic             issue_rdy,
  input logic             ld_req_valid,
  input logic             ld_req_ready,
  input logic [XLEN-1:0]  ld_addr,
  input logic             ld_dword,
  input logic             ld_signed,
  input logic             ld_data_valid,
  input logic             wb_valid,
  input logic             illegal
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_req_valid && !ld_req_ready) |=>
      (ld_req_valid && $stable(ld_addr) && $stable(ld_dword) && $stable(ld_signed)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    ld_req_valid |-> !issue_rdy);

  assert_data_wb_R9: assert property (@(posedge clk) disable iff (rst)
    (!issue_rdy && !ld_req_valid && ld_data_valid) |=> (wb_valid && issue_rdy));

  assert_dw_align_R7: assert property (@(posedge clk) disable iff (rst)
    (ld_req_valid && ld_dword) |-> (ld_addr[2:0] == 3'b000));

  assert_addimm_1cyc_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_rdy && in_valid && (in_imm[IMM_W-1 -: 2] == 2'b00)) |=> wb_valid);

  assert_bad_nowb_R10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wb_valid && !ld_req_valid));

endmodule

bind pcrel_unit pcrel_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_imm        (in_imm),
  .issue_rdy     (issue_rdy),
  .ld_req_valid  (ld_req_valid),
  .ld_req_ready  (ld_req_ready),
  .ld_addr       (ld_addr),
  .ld_dword      (ld_dword),
  .ld_signed     (ld_signed),
  .ld_data_valid (ld_data_valid),
  .wb_valid      (wb_valid),
  .illegal       (illegal)
);

// File: tb/pcrel_unit_tb.sv
module pcrel_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_pc;
  logic [20:0] in_imm;
  logic [4:0]  in_dst;
  logic        issue_rdy, ld_req_valid, ld_req_ready;
  logic [63:0] ld_addr;
  logic        ld_dword, ld_signed, ld_data_valid;
  logic [63:0] ld_data;
  logic        wb_valid;
  logic [4:0]  wb_reg;
  logic [63:0] wb_data;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcrel_unit #(.XLEN(64), .IMM_W(21), .REG_W(5)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pc(in_pc), .in_imm(in_imm),
    .in_dst(in_dst), .issue_rdy(issue_rdy), .ld_req_valid(ld_req_valid),
    .ld_req_ready(ld_req_ready), .ld_addr(ld_addr), .ld_dword(ld_dword),
    .ld_signed(ld_signed), .ld_data_valid(ld_data_valid), .ld_data(ld_data),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data), .illegal(illegal)
  );

  typedef struct {
    logic        bad;
    logic        ld;
    logic        dw;
    logic        sg;
    logic [63:0] addr;
    logic [4:0]  rg;
    logic [63:0] d;
    string       tag;
    int          stall;
    int          gap;
  } exp_t;

  exp_t sbq[$];
  exp_t ldq[$];

  task automatic check(input string tag, input bit ok, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_fn(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_0F0F, a[31:0] ^ 32'hC001_D00D};
  endfunction

  // Expected outcome written from the requirements
  function automatic exp_t model(input logic [63:0] p, input logic [20:0] im, input logic [4:0] rg,
                                 input string tag, input int stall, input int gap);
    exp_t e;
    logic [63:0] se16, se19, se18, raw;
    se16 = {{48{im[15]}}, im[15:0]};
    se19 = {{45{im[18]}}, im[18:0]};
    se18 = {{46{im[17]}}, im[17:0]};
    e.bad = 0; e.ld = 0; e.dw = 0; e.sg = 0; e.addr = '0; e.d = '0;
    e.rg = rg; e.tag = tag; e.stall = stall; e.gap = gap;
    if (im[20:16] == 5'b11110) e.d = p + (se16 << 16);                       // R2
    else if (im[20:16] == 5'b11111) e.d = (p + (se16 << 16)) & ~64'hFFFF;    // R3
    else if (im[20:18] == 3'b110) begin                                      // R7
      e.ld = 1; e.dw = 1; e.addr = (p & ~64'h7) + (se18 << 3);
      e.d = mem_fn(e.addr);
    end else begin
      case (im[20:19])
        2'b00: e.d = p + (se19 << 2);                                        // R4
        2'b01: begin e.ld = 1; e.sg = 1; e.addr = p + (se19 << 2);           // R5
                 raw = mem_fn(e.addr); e.d = {{32{raw[31]}}, raw[31:0]}; end
        2'b10: begin e.ld = 1; e.addr = p + (se19 << 2);                     // R6
                 raw = mem_fn(e.addr); e.d = {32'h0, raw[31:0]}; end
        default: e.bad = 1;                                                  // R10
      endcase
    end
    return e;
  endfunction

  // Driver
  task automatic send(input logic [63:0] p, input logic [20:0] im, input logic [4:0] rg,
                      input string tag, input int stall, input int gap);
    exp_t e;
    e = model(p, im, rg, tag, stall, gap);
    @(negedge clk);
    while (!issue_rdy) @(negedge clk);
    sbq.push_back(e);
    if (e.ld) ldq.push_back(e);
    in_valid = 1'b1; in_pc = p; in_imm = im; in_dst = rg;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      if (!rst && (wb_valid || illegal)) begin
        if (sbq.size() == 0) begin
          check("R9 unexpected output", 1'b0, {illegal, wb_valid, wb_reg, wb_data}, '0);
        end else begin
          e = sbq.pop_front();
          // R11: register number compared on every result
          check(e.tag, {illegal, wb_valid, wb_reg, wb_data} == {e.bad, !e.bad, e.bad ? wb_reg : e.rg, e.bad ? wb_data : e.d},
                {illegal, wb_valid, wb_reg, wb_data}, {e.bad, !e.bad, e.rg, e.d});
        end
      end
    end
  end

  // Memory model
  initial begin
    ld_req_ready = 1'b0; ld_data_valid = 1'b0; ld_data = '0;
    forever begin
      exp_t m;
      @(negedge clk);
      if (!rst && ld_req_valid) begin
        if (ldq.size() == 0) begin
          check("R10 unexpected load request", 1'b0, ld_addr, '0);
        end else begin
          m = ldq.pop_front();
          check({m.tag, " request"}, {ld_addr, ld_dword, ld_signed} == {m.addr, m.dw, m.sg},
                {ld_addr, ld_dword, ld_signed}, {m.addr, m.dw, m.sg});
          for (int i = 0; i < m.stall; i++) begin
            @(negedge clk);
            check("R8 hold", ld_req_valid && ld_addr == m.addr && ld_dword == m.dw && ld_signed == m.sg,
                  {ld_req_valid, ld_addr}, {1'b1, m.addr});
          end
          ld_req_ready = 1'b1;
          @(negedge clk);
          ld_req_ready = 1'b0;
          check("R9 busy after accept", !ld_req_valid && !issue_rdy, {ld_req_valid, issue_rdy}, 2'b00);
          for (int i = 0; i < m.gap; i++) begin
            @(negedge clk);
            check("R9 busy waiting", !issue_rdy && !wb_valid, {issue_rdy, wb_valid}, 2'b00);
          end
          ld_data_valid = 1'b1; ld_data = mem_fn(m.addr);
          @(negedge clk);
          ld_data_valid = 1'b0; ld_data = 64'hDEAD_BEEF_DEAD_BEEF;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_pc = '0; in_imm = '0; in_dst = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", issue_rdy && !wb_valid && !ld_req_valid && !illegal,
          {issue_rdy, wb_valid, ld_req_valid, illegal}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", issue_rdy && !wb_valid && !ld_req_valid && !illegal,
          {issue_rdy, wb_valid, ld_req_valid, illegal}, 4'b1000);

    send(64'h0000_0000_1234_5678, {5'b11110, 16'h0001}, 5'd1,  "R2 positive", 0, 0);
    send(64'h0000_0000_1234_5678, {5'b11110, 16'h8000}, 5'd2,  "R2 negative", 0, 0);
    send(64'h0000_0000_1234_5678, {5'b11111, 16'h0003}, 5'd3,  "R3 aligned", 0, 0);
    send(64'hFFFF_FFFF_FFFF_FFFF, {5'b11111, 16'hFFFF}, 5'd4,  "R3 wrap", 0, 0);
    send(64'h0000_0000_1234_5678, {2'b00, 19'h7FFFF},   5'd5,  "R4 minus one", 0, 0);
    send(64'h0000_0000_FFFF_FFFC, {2'b00, 19'h00001},   5'd6,  "R4 carry bit 32", 0, 0);
    send(64'h0000_0000_0000_1000, {2'b00, 19'h40000},   5'd7,  "R4 most negative", 0, 0);
    send(64'h0000_0000_1234_5678, {2'b01, 19'h00020},   5'd8,  "R5 signed word", 0, 0);
    send(64'h0000_0000_8234_5678, {2'b01, 19'h00004},   5'd9,  "R5 positive word", 2, 1);
    send(64'h0000_0000_1234_5678, {2'b10, 19'h7FFF0},   5'd10, "R6 unsigned word", 3, 2);
    send(64'h0000_0000_1234_5677, {3'b110, 18'h3FFFF},  5'd11, "R7 dword back", 1, 0);
    send(64'h0000_0000_0000_0005, {3'b110, 18'h00002},  5'd12, "R7 dword fwd", 4, 3);
    send(64'h0000_0000_1234_5678, {5'b11100, 16'h1234}, 5'd13, "R10 code 11100", 0, 0);
    send(64'h0000_0000_1234_5678, {5'b11101, 16'h0000}, 5'd14, "R10 code 11101", 0, 0);
    send(64'h0000_0000_0000_0040, {2'b00, 19'h00003},   5'd31, "R11 top register", 0, 0);

    // R9: issue during an outstanding load is ignored
    send(64'h0000_0000_2000_0000, {2'b10, 19'h00001},   5'd15, "R9 load before stray", 3, 2);
    in_valid = 1'b1; in_pc = 64'h10; in_imm = {2'b00, 19'h1}; in_dst = 5'd16;
    @(negedge clk);
    in_valid = 1'b0;
    send(64'h0000_0000_0000_0100, {5'b11110, 16'h0002}, 5'd17, "R9 issue after load", 0, 0);

    for (int i = 0; i < 50 && (sbq.size() != 0 || ldq.size() != 0); i++) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R9 all results drained", sbq.size() == 0 && ldq.size() == 0, sbq.size(), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule